// File: doc/BRIEF.md
# Gated 13/16-bit Timer/Counter

This block is one timer/counter channel in the style of a small 8-bit controller. Its count register is held as a high byte and a low byte. A mode input selects between a 13-bit chain, built from the full high byte and the bottom five bits of the low byte, and a full 16-bit chain.

Each count step comes from one of two sources. In timer mode it is a strobe produced once every six clocks. In counter mode it is a falling edge seen on an external pin. A count step is accepted only while the run bit is set and the gate condition passes: either gating is disabled, or the external gate pin is high. Holding the gate pin high for a measured interval therefore lets software time a pulse width.

Software loads either byte through write strobes. Rolling the count over from all ones to all zeros raises a sticky overflow flag. The flag stays set until software clears it or an interrupt-acknowledge pulse arrives.

Top module: `gtmr_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, both count bytes read 0 and the overflow flag reads 0.
- R2: A count step is applied only when runEn=1 and (gateEn=0 or extGate=1). In every other combination the count bytes hold their values.
- R3: With cntSel=0, the step source is a strobe on every sixth rising clock edge after reset release (edges 6, 12, 18, …). The strobe runs freely, whatever the values of runEn and gateEn.
- R4: With cntSel=1, one step is taken per falling edge of cntPin. The step lands on the clock edge that follows the edge which first samples the pin low after it was sampled high.
- R5: With modeWide=0, the counter is {cntHi, cntLo[4:0]}. A carry out of cntLo bit 4 increments cntHi, and cntLo[7:5] never changes on a count step.
- R6: With modeWide=1, {cntHi, cntLo} counts as one 16-bit value.
- R7: A count step taken while the active counter is all ones wraps it to zero and sets ovfFlag on the same clock edge.
- R8: ovfFlag stays set until a cycle in which flagClr=1 or intAck=1. If a wrap happens in that same cycle, the flag is set and not cleared.
- R9: In a cycle where wrHi or wrLo is high, the written byte takes wrData and no count step is applied to either byte.
- R10: Changing runEn does not alter the count bytes; counting resumes from the held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeWide | input | 1 | 0: 13-bit chain, 1: 16-bit chain |
| cntSel | input | 1 | 0: divided clock, 1: external pin edges |
| gateEn | input | 1 | Enables gating by extGate |
| runEn | input | 1 | Run bit |
| extGate | input | 1 | External gate pin |
| cntPin | input | 1 | External count pin |
| wrHi | input | 1 | Load high byte from wrData |
| wrLo | input | 1 | Load low byte from wrData |
| wrData | input | 8 | Load data |
| flagClr | input | 1 | Software clear of overflow flag |
| intAck | input | 1 | Interrupt-serviced pulse, clears flag |
| cntHi | output | 8 | High count byte |
| cntLo | output | 8 | Low count byte |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The count bytes are outputs, so a wrong increment, a lost carry or a disturbed cntLo[7:5] appears at the ports on the next clock edge. The bench compares the bytes every cycle and catches such a fault within one cycle. A prescaler phase error, or a pin edge detected one sample late, shifts every later step by a fixed number of cycles. Because the comparison runs every cycle, it shows as a miscompare at the first step after the fault. A flag fault becomes visible only at a wrap or a clear, so the bench forces rollovers from loaded values close to all ones, in both modes and from both sources.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  // Strobes from control to datapath, one bundle per cycle
  typedef struct packed {
    logic countEn;
    logic wrHi;
    logic wrLo;
    logic clrFlag;
  } gtmrStrobe_t;
endpackage

// File: rtl/gtmr_ctrl.sv
module gtmr_ctrl
  import gtmr_pkg::*;
#(
  parameter int PRESCALE = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cntSel,
  input  logic        gateEn,
  input  logic        runEn,
  input  logic        extGate,
  input  logic        cntPin,
  input  logic        wrHi,
  input  logic        wrLo,
  input  logic        flagClr,
  input  logic        intAck,
  output gtmrStrobe_t strobe
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic preTick;

  generate
    if (PRESCALE > 1) begin : g_div
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) preCnt <= '0;
        else if (preCnt == PRE_W'(PRESCALE - 1)) preCnt <= '0;
        else preCnt <= preCnt + PRE_W'(1);
      end
      assign preTick = (preCnt == PRE_W'(PRESCALE - 1));

      // R3: strobe is a single-cycle pulse
      p_tick_single_r3: assert property (@(posedge clk) disable iff (!rstN)
        preTick |=> !preTick);
    end else begin : g_nodiv
      assign preTick = 1'b1;
    end
  endgenerate

  // Pin sampler: two stages, falling edge = old high, new low
  logic pinS0, pinS1, pinFell;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinS0 <= 1'b0;
      pinS1 <= 1'b0;
    end else begin
      pinS0 <= cntPin;
      pinS1 <= pinS0;
    end
  end
  assign pinFell = pinS1 & ~pinS0;

  logic gateOk;
  assign gateOk = runEn & (~gateEn | extGate);

  always_comb begin
    strobe.countEn = gateOk & (cntSel ? pinFell : preTick);
    strobe.wrHi    = wrHi;
    strobe.wrLo    = wrLo;
    strobe.clrFlag = flagClr | intAck;
  end

  // R4: a detected edge cannot repeat in the next cycle
  p_edge_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    pinFell |=> !pinFell);
endmodule

// File: rtl/gtmr_dpath.sv
module gtmr_dpath
  import gtmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LOW13_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWide,
  input  logic [BYTE_W-1:0] wrData,
  input  gtmrStrobe_t       strobe,
  output logic [BYTE_W-1:0] hiQ,
  output logic [BYTE_W-1:0] loQ,
  output logic              flagQ
);
  localparam int WIDE_W = 2 * BYTE_W;
  localparam int NARROW_W = BYTE_W + LOW13_W;

  logic [WIDE_W-1:0]   sumWide;
  logic [NARROW_W-1:0] sumNarrow;
  logic wrapNow, anyWr, stepNow;

  assign sumWide   = {hiQ, loQ} + WIDE_W'(1);
  assign sumNarrow = {hiQ, loQ[LOW13_W-1:0]} + NARROW_W'(1);
  assign wrapNow   = modeWide ? (&{hiQ, loQ}) : (&{hiQ, loQ[LOW13_W-1:0]});
  assign anyWr     = strobe.wrHi | strobe.wrLo;
  assign stepNow   = strobe.countEn & ~anyWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ <= '0;
      loQ <= '0;
    end else if (anyWr) begin
      if (strobe.wrHi) hiQ <= wrData;
      if (strobe.wrLo) loQ <= wrData;
    end else if (strobe.countEn) begin
      if (modeWide) begin
        {hiQ, loQ} <= sumWide;
      end else begin
        hiQ <= sumNarrow[NARROW_W-1:LOW13_W];
        loQ[LOW13_W-1:0] <= sumNarrow[LOW13_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= 1'b0;
    else if (stepNow && wrapNow) flagQ <= 1'b1;
    else if (strobe.clrFlag) flagQ <= 1'b0;
  end

  // R2: no step and no write leaves both bytes unchanged
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countEn && !anyWr) |=> ($stable(hiQ) && $stable(loQ)));
  // R9: a high-byte write lands as written
  p_wr_hi_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrHi |=> (hiQ == $past(wrData)));
  // R5: upper low-byte bits are frozen in 13-bit mode unless written
  p_lo_upper_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!modeWide && !strobe.wrLo) |=> (loQ[BYTE_W-1:LOW13_W] == $past(loQ[BYTE_W-1:LOW13_W])));
  // R7: a wrapping step raises the flag and zeroes the chain
  p_wrap_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && wrapNow) |=> (flagQ && hiQ == '0));
  // R8: without a set or clear the flag keeps its value
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!stepNow && !strobe.clrFlag) |=> $stable(flagQ));
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
  import gtmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LOW13_W = 5,
  parameter int PRESCALE = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWide,
  input  logic              cntSel,
  input  logic              gateEn,
  input  logic              runEn,
  input  logic              extGate,
  input  logic              cntPin,
  input  logic              wrHi,
  input  logic              wrLo,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              flagClr,
  input  logic              intAck,
  output logic [BYTE_W-1:0] cntHi,
  output logic [BYTE_W-1:0] cntLo,
  output logic              ovfFlag
);
  gtmrStrobe_t strobe;

  gtmr_ctrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntSel(cntSel), .gateEn(gateEn), .runEn(runEn),
    .extGate(extGate), .cntPin(cntPin), .wrHi(wrHi), .wrLo(wrLo),
    .flagClr(flagClr), .intAck(intAck), .strobe(strobe)
  );

  gtmr_dpath #(.BYTE_W(BYTE_W), .LOW13_W(LOW13_W)) u_dpath (
    .clk(clk), .rstN(rstN), .modeWide(modeWide), .wrData(wrData),
    .strobe(strobe), .hiQ(cntHi), .loQ(cntLo), .flagQ(ovfFlag)
  );
endmodule

// File: tb/sim_gtmr_top.sv
module sim_gtmr_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWide = 1'b1, cntSel = 1'b0, gateEn = 1'b0, runEn = 1'b0;
  logic extGate = 1'b0, cntPin = 1'b0, wrHi = 1'b0, wrLo = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic flagClr = 1'b0, intAck = 1'b0;
  logic [7:0] cntHi, cntLo;
  logic ovfFlag;

  int vecCnt = 0, errCnt = 0, cycles = 0;
  string curReq = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gtmr_top u0 (
    .clk(clk), .rstN(rstN), .modeWide(modeWide), .cntSel(cntSel), .gateEn(gateEn),
    .runEn(runEn), .extGate(extGate), .cntPin(cntPin), .wrHi(wrHi), .wrLo(wrLo),
    .wrData(wrData), .flagClr(flagClr), .intAck(intAck),
    .cntHi(cntHi), .cntLo(cntLo), .ovfFlag(ovfFlag)
  );

  // Reference model written from the requirements
  logic [7:0] mHi, mLo;
  logic mFlag;
  int mEdge;
  logic pinA, pinB;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mHi = 8'h00; mLo = 8'h00; mFlag = 1'b0; mEdge = 0; pinA = 1'b0; pinB = 1'b0;
    end else begin
      logic tick, fell, en, wrap, wr;
      logic [12:0] n13;
      mEdge = mEdge + 1;
      tick = (mEdge % 6) == 0;                    // R3
      fell = pinB & ~pinA;                        // R4
      pinB = pinA; pinA = cntPin;
      en = runEn && (!gateEn || extGate) && (cntSel ? fell : tick); // R2
      wrap = modeWide ? ({mHi, mLo} == 16'hFFFF) : (mHi == 8'hFF && mLo[4:0] == 5'h1F);
      wr = wrHi || wrLo;
      if (wr) begin                               // R9
        if (wrHi) mHi = wrData;
        if (wrLo) mLo = wrData;
      end else if (en) begin
        if (modeWide) {mHi, mLo} = {mHi, mLo} + 16'd1;   // R6
        else begin                                        // R5
          n13 = {mHi, mLo[4:0]} + 13'd1;
          mHi = n13[12:5];
          mLo = {mLo[7:5], n13[4:0]};
        end
      end
      if (en && wrap && !wr) mFlag = 1'b1;        // R7
      else if (flagClr || intAck) mFlag = 1'b0;   // R8
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      vecCnt++;
      if (cntHi !== mHi || cntLo !== mLo || ovfFlag !== mFlag) begin
        errCnt++;
        $display("FAIL %s: got hi=%h lo=%h flag=%b, expected hi=%h lo=%h flag=%b",
                 curReq, cntHi, cntLo, ovfFlag, mHi, mLo, mFlag);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadBytes(logic [7:0] h, logic [7:0] l);
    wrHi = 1'b1; wrData = h; step(1);
    wrHi = 1'b0; wrLo = 1'b1; wrData = l; step(1);
    wrLo = 1'b0;
  endtask

  task automatic pinPulses(int n, int hiLen, int loLen);
    for (int i = 0; i < n; i++) begin
      cntPin = 1'b1; step(hiLen);
      cntPin = 1'b0; step(loLen);
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errCnt++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1: reset values while reset asserted
    vecCnt++;
    if (cntHi !== 8'h00 || cntLo !== 8'h00 || ovfFlag !== 1'b0) begin
      errCnt++;
      $display("FAIL R1: got %h %h %b, expected 00 00 0", cntHi, cntLo, ovfFlag);
    end
    rstN = 1'b1;
    step(2);

    // R3/R6: timer, 16-bit, free run
    curReq = "R3"; runEn = 1'b1; step(60);
    // R6/R7: roll over 16-bit
    curReq = "R7"; loadBytes(8'hFF, 8'hF8); step(80);
    // R8: software clear then ack clear
    curReq = "R8"; flagClr = 1'b1; step(1); flagClr = 1'b0; step(3);
    loadBytes(8'hFF, 8'hFF); step(10);
    intAck = 1'b1; step(1); intAck = 1'b0; step(3);
    // R8: clear held across a wrap, set wins
    loadBytes(8'hFF, 8'hFE); flagClr = 1'b1; step(20); flagClr = 1'b0; step(4);

    // R5: 13-bit chain with junk in upper low bits
    curReq = "R5"; modeWide = 1'b0;
    loadBytes(8'h12, 8'hA0); step(250);
    loadBytes(8'hFF, 8'hBC); step(60);
    curReq = "R7"; flagClr = 1'b1; step(1); flagClr = 1'b0;
    loadBytes(8'hFF, 8'h5F); step(12);

    // R2: sweep run/gate/ext in both widths
    curReq = "R2";
    for (int w = 0; w < 2; w++) begin
      modeWide = w[0];
      for (int c = 0; c < 8; c++) begin
        runEn = c[0]; gateEn = c[1]; extGate = c[2];
        step(19);
      end
    end

    // R10: run off then on holds count
    curReq = "R10"; gateEn = 1'b0; runEn = 1'b1; modeWide = 1'b1;
    loadBytes(8'h40, 8'h10); step(30);
    runEn = 1'b0; step(40); runEn = 1'b1; step(30);

    // R4: external edges, various pulse shapes
    curReq = "R4"; cntSel = 1'b1;
    for (int hl = 1; hl <= 3; hl++)
      for (int ll = 1; ll <= 3; ll++)
        pinPulses(5, hl, ll);
    // R4/R7: wrap via pin in 13-bit mode
    modeWide = 1'b0; loadBytes(8'hFF, 8'h1D); pinPulses(4, 2, 2);
    // R2: gated pulse-width measurement in counter mode
    curReq = "R2"; gateEn = 1'b1; extGate = 1'b0; pinPulses(6, 1, 2);
    extGate = 1'b1; pinPulses(6, 2, 1); extGate = 1'b0; pinPulses(3, 1, 1);

    // R9: writes collide with count steps
    curReq = "R9"; cntSel = 1'b0; gateEn = 1'b0; modeWide = 1'b1;
    for (int k = 0; k < 14; k++) begin
      wrHi = 1'b1; wrData = 8'(k * 17); step(1);
    end
    wrHi = 1'b0;
    for (int k = 0; k < 14; k++) begin
      wrLo = 1'b1; wrData = 8'hFF; step(1);
    end
    wrLo = 1'b0; step(20);
    // R9: write on the wrap cycle blocks the flag
    flagClr = 1'b1; step(1); flagClr = 1'b0;
    loadBytes(8'hFF, 8'hFF);
    wrLo = 1'b1; wrData = 8'hFF; step(12); wrLo = 1'b0; step(8);

    step(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule